// File: doc/BRIEF.md
# Scatter-Gather List Walker

This block takes one data transfer and breaks it into bursts, one for each buffer segment described in a chain of scatter-gather entries held in memory. A pulse on `start` hands over the list's base address, the transfer direction and the number of bytes the transfer needs. The walker then fetches the entries one at a time through a single-word memory read port. For each entry it presents a segment on the segment port, made of a 64-bit buffer address and a byte count, and holds it until the consumer signals `seg_done`.

Each entry is 16 bytes: a 64-bit buffer address, then a 32-bit byte count, then a 32-bit flags word. Bit 31 of the flags word marks the final entry of the chain. A command slot holds at most `MAX_ENT` entries (six by default). The walk ends successfully once the requested byte total has been handed out. It ends with an error code if the list is exhausted first, and the code depends on whether data was going to the device or coming from it. A base address that is not 8-byte aligned is rejected before any read.

Top module: `sg_walker`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `seg_valid` and `rd_req` are all 0, and `err_code` is 0.
- R2: Entry k of a walk is read as four 32-bit little-endian words at byte addresses base+16k+0, +4, +8 and +12, in that order. Word 0 is address bits 31:0, word 1 is address bits 63:32, word 2 is the byte count and word 3 is the flags word. Each `rd_req` is a one-cycle pulse carrying a word-aligned `rd_addr`.
- R3: Each entry yields one segment whose address is the entry's buffer address and whose length is the smaller of the entry count and the bytes still remaining. An entry whose length would be zero yields no segment.
- R4: The remaining byte count is reduced by the segment length at each `seg_done`. When it reaches zero, `done` pulses for one cycle, `busy` drops and no further read is issued, even if the terminate flag has not been seen.
- R5: If an entry with flags bit 31 set is finished while bytes remain, the walk stops with `err`=1 and `err_code`=7 when `dir_wr`=1 (to device), or `err_code`=8 when `dir_wr`=0 (from device).
- R6: If entry number `MAX_ENT`-1 is finished while bytes remain and no terminate flag was seen, the walk stops with the same code as R5.
- R7: A start whose `list_base` has any of bits 2:0 set produces `err`=1 and `err_code`=16 on the next cycle, with no read issued.
- R8: A start with an aligned base and `total_len`=0 pulses `done` on the next cycle, with no read and no segment.
- R9: `err` and `err_code` hold until the next accepted start, which clears them. No segment and no read is presented while `err` is 1.
- R10: A `start` pulse that arrives while `busy` is 1 is ignored and does not disturb the walk in progress.
- R11: At most one read is outstanding at any time. `seg_valid`, `seg_addr` and `seg_len` stay stable until `seg_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (accepted only when idle) |
| list_base | input | ADDR_W | Byte address of the first entry |
| dir_wr | input | 1 | 1: data goes to the device, 0: data comes from it |
| total_len | input | 32 | Bytes the transfer needs |
| rd_req | output | 1 | One-cycle memory read request |
| rd_addr | output | ADDR_W | Byte address of the requested word |
| rd_valid | input | 1 | Read data is valid this cycle |
| rd_data | input | 32 | Read data word |
| seg_valid | output | 1 | A segment is being presented |
| seg_addr | output | 64 | Segment buffer address |
| seg_len | output | 32 | Segment byte count |
| seg_done | input | 1 | Consumer has finished the presented segment |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| err | output | 1 | Sticky error flag |
| err_code | output | 6 | Error code: 7, 8 or 16 |

## Verification
A wrong remaining-byte count shows up as a wrong `seg_len` on the next segment, or as a `done` or error that arrives one entry early or late. That difference is visible within one entry fetch, which is four reads. A wrong entry index shows up at once on `rd_addr` at the next fetch. A wrong terminate or limit decision shows up as a wrong code, or as extra reads beyond the expected count. A stale direction bit shows up as code 7 where 8 was due, or the reverse, so the bench covers both directions for every kind of list exhaustion.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

  localparam int ERR_W = 6;
  localparam logic [ERR_W-1:0] CODE_RUNOUT_WR = 6'd7;
  localparam logic [ERR_W-1:0] CODE_RUNOUT_RD = 6'd8;
  localparam logic [ERR_W-1:0] CODE_ALIGN     = 6'd16;
  localparam int TERM_BIT = 31;
  localparam int ENT_BYTES = 16;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SEG
  } sgw_state_e;

  typedef struct packed {
    logic [63:0] buf_addr;
    logic [31:0] byte_cnt;
    logic [31:0] flags;
  } sg_entry_t;

  // length of the burst an entry may produce
  function automatic logic [31:0] clip_len(input logic [31:0] cnt,
                                           input logic [31:0] rem);
    return (cnt < rem) ? cnt : rem;
  endfunction

  // code raised when the list is exhausted before the transfer ends
  function automatic logic [ERR_W-1:0] runout_code(input logic to_dev);
    return to_dev ? CODE_RUNOUT_WR : CODE_RUNOUT_RD;
  endfunction

endpackage

// File: rtl/sgw_fetch.sv
module sgw_fetch
  import sgw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] ent_base,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [31:0]       rd_data,
  output logic              ent_vld,
  output sg_entry_t         ent
);

  localparam int NWORDS = ENT_BYTES / 4;
  localparam int WIDX_W = $clog2(NWORDS);

  logic              active;
  logic              req_q;
  logic [WIDX_W-1:0] widx;
  logic [ADDR_W-1:0] base_q;
  logic [31:0]       words [NWORDS];
  logic              word_in;
  logic              last_word;

  assign word_in   = rd_valid && active;
  assign last_word = (widx == WIDX_W'(NWORDS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      req_q   <= 1'b0;
      widx    <= '0;
      base_q  <= '0;
      ent_vld <= 1'b0;
    end else begin
      ent_vld <= 1'b0;
      req_q   <= 1'b0;
      if (go) begin
        active <= 1'b1;
        widx   <= '0;
        base_q <= ent_base;
        req_q  <= 1'b1;
      end else if (word_in) begin
        if (last_word) begin
          active  <= 1'b0;
          ent_vld <= 1'b1;
        end else begin
          widx  <= widx + 1'b1;
          req_q <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) words[g] <= '0;
      else if (word_in && widx == WIDX_W'(g)) words[g] <= rd_data;
    end
  end

  assign rd_req  = req_q;
  assign rd_addr = base_q + {{(ADDR_W-WIDX_W-2){1'b0}}, widx, 2'b00};

  assign ent.buf_addr = {words[1], words[0]};
  assign ent.byte_cnt = words[2];
  assign ent.flags    = words[3];

endmodule

// File: rtl/sgw_ctl.sv
module sgw_ctl
  import sgw_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int MAX_ENT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] list_base,
  input  logic              dir_wr,
  input  logic [31:0]       total_len,
  output logic              fetch_go,
  output logic [ADDR_W-1:0] ent_base,
  input  logic              ent_vld,
  input  sg_entry_t         ent,
  output logic              seg_valid,
  output logic [63:0]       seg_addr,
  output logic [31:0]       seg_len,
  input  logic              seg_done,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [ERR_W-1:0]  err_code
);

  localparam int IDX_W = (MAX_ENT > 1) ? $clog2(MAX_ENT) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MAX_ENT - 1);

  sgw_state_e       state;
  logic [31:0]      rem;
  logic [IDX_W-1:0] idx;
  logic             last_q;
  logic             to_dev_q;

  // named events
  logic        start_acc;
  logic        misalign;
  logic [31:0] ent_clip;
  logic        ent_zero;
  logic        seg_fin;
  logic        step;
  logic [31:0] rem_next;
  logic        last_cur;
  logic        walk_ok;
  logic        runout;

  assign start_acc = start && (state == ST_IDLE);
  assign misalign  = |list_base[2:0];
  assign ent_clip  = clip_len(ent.byte_cnt, rem);
  assign ent_zero  = (state == ST_FETCH) && ent_vld && (ent_clip == '0);
  assign seg_fin   = (state == ST_SEG) && seg_done;
  assign step      = seg_fin || ent_zero;
  assign rem_next  = seg_fin ? (rem - seg_len) : rem;
  assign last_cur  = (state == ST_FETCH) ? ent.flags[TERM_BIT] : last_q;
  assign walk_ok   = step && (rem_next == '0);
  assign runout    = step && !walk_ok && (last_cur || idx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      rem      <= '0;
      idx      <= '0;
      last_q   <= 1'b0;
      to_dev_q <= 1'b0;
      fetch_go <= 1'b0;
      ent_base <= '0;
      seg_addr <= '0;
      seg_len  <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      err_code <= '0;
    end else begin
      done     <= 1'b0;
      fetch_go <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_acc) begin
            err      <= 1'b0;
            err_code <= '0;
            if (misalign) begin
              err      <= 1'b1;
              err_code <= CODE_ALIGN;
            end else if (total_len == '0) begin
              done <= 1'b1;
            end else begin
              rem      <= total_len;
              idx      <= '0;
              to_dev_q <= dir_wr;
              ent_base <= list_base;
              fetch_go <= 1'b1;
              state    <= ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          if (ent_vld) begin
            last_q <= ent.flags[TERM_BIT];
            if (ent_clip != '0) begin
              seg_addr <= ent.buf_addr;
              seg_len  <= ent_clip;
              state    <= ST_SEG;
            end
          end
        end
        default: ;
      endcase

      if (step) begin
        rem <= rem_next;
        if (walk_ok) begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end else if (runout) begin
          err      <= 1'b1;
          err_code <= runout_code(to_dev_q);
          state    <= ST_IDLE;
        end else begin
          idx      <= idx + 1'b1;
          ent_base <= ent_base + ADDR_W'(ENT_BYTES);
          fetch_go <= 1'b1;
          state    <= ST_FETCH;
        end
      end
    end
  end

  assign seg_valid = (state == ST_SEG);
  assign busy      = (state != ST_IDLE);

endmodule

// File: rtl/sg_walker.sv
module sg_walker
  import sgw_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int MAX_ENT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] list_base,
  input  logic              dir_wr,
  input  logic [31:0]       total_len,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [31:0]       rd_data,
  output logic              seg_valid,
  output logic [63:0]       seg_addr,
  output logic [31:0]       seg_len,
  input  logic              seg_done,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [5:0]        err_code
);

  logic              fetch_go;
  logic [ADDR_W-1:0] ent_base;
  logic              ent_vld;
  sg_entry_t         ent;

  sgw_fetch #(.ADDR_W(ADDR_W)) fetch_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (fetch_go),
    .ent_base (ent_base),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .ent_vld  (ent_vld),
    .ent      (ent)
  );

  sgw_ctl #(.ADDR_W(ADDR_W), .MAX_ENT(MAX_ENT)) ctl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .list_base (list_base),
    .dir_wr    (dir_wr),
    .total_len (total_len),
    .fetch_go  (fetch_go),
    .ent_base  (ent_base),
    .ent_vld   (ent_vld),
    .ent       (ent),
    .seg_valid (seg_valid),
    .seg_addr  (seg_addr),
    .seg_len   (seg_len),
    .seg_done  (seg_done),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .err_code  (err_code)
  );

endmodule

// File: rtl/sgw_chk.sv
module sgw_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [ADDR_W-1:0] list_base,
  input logic [31:0]       total_len,
  input logic              rd_req,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_valid,
  input logic              seg_valid,
  input logic [63:0]       seg_addr,
  input logic [31:0]       seg_len,
  input logic              seg_done,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [5:0]        err_code
);

  logic [1:0] outst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outst <= '0;
    else outst <= outst + {1'b0, rd_req} - {1'b0, rd_valid};
  end

  a_r11_one_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (outst == 2'd0));

  a_r11_seg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && !seg_done) |=> (seg_valid && $stable(seg_addr) && $stable(seg_len)));

  a_r2_read_shape: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (busy && rd_addr[1:0] == 2'b00));

  a_r3_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> (seg_len != 32'd0));

  a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !err));

  a_r7_misalign: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && list_base[2:0] != 3'b000) |=> (err && err_code == 6'd16 && !busy && !rd_req));

  a_r8_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && list_base[2:0] == 3'b000 && total_len == 32'd0) |=> (done && !busy && !rd_req));

  a_r9_quiet_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!seg_valid && !rd_req));

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !(start && !busy)) |=> (err && $stable(err_code)));

endmodule

bind sg_walker sgw_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .list_base (list_base),
  .total_len (total_len),
  .rd_req    (rd_req),
  .rd_addr   (rd_addr),
  .rd_valid  (rd_valid),
  .seg_valid (seg_valid),
  .seg_addr  (seg_addr),
  .seg_len   (seg_len),
  .seg_done  (seg_done),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .err_code  (err_code)
);

// File: tb/sg_walker_tb_top.sv
`timescale 1ns/1ps
module sg_walker_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] list_base = '0;
  logic        dir_wr = 1'b0;
  logic [31:0] total_len = '0;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic        rd_valid = 1'b0;
  logic [31:0] rd_data = '0;
  logic        seg_valid;
  logic [63:0] seg_addr;
  logic [31:0] seg_len;
  logic        seg_done = 1'b0;
  logic        busy, done, err;
  logic [5:0]  err_code;

  always #2.5 clk = ~clk;

  sg_walker dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .list_base(list_base),
    .dir_wr(dir_wr), .total_len(total_len), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .seg_valid(seg_valid),
    .seg_addr(seg_addr), .seg_len(seg_len), .seg_done(seg_done),
    .busy(busy), .done(done), .err(err), .err_code(err_code)
  );

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  logic [31:0] mem [256];
  logic [63:0] ea [6];
  logic [31:0] ec [6];
  logic [31:0] ef [6];

  logic [63:0] got_a [8];
  logic [31:0] got_l [8];
  logic [63:0] xa [8];
  logic [31:0] xl [8];
  int nseg = 0;
  int nreads = 0;
  int rd_bad = 0;
  int done_cnt = 0;
  logic [31:0] cur_base = '0;
  int rd_cd = 0;
  int sg_cd = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // memory responder with checked read order (R2)
  always @(negedge clk) begin
    if (rd_valid) rd_valid = 1'b0;
    if (rd_cd > 0) begin
      rd_cd--;
      if (rd_cd == 0) rd_valid = 1'b1;
    end
    if (rd_req) begin
      if (rd_addr != cur_base + 32'((nreads / 4) * 16 + (nreads % 4) * 4)) rd_bad++;
      rd_data = mem[rd_addr[9:2]];
      rd_cd = 1 + int'($urandom % 3);
      nreads++;
    end
  end

  // segment consumer
  always @(negedge clk) begin
    if (seg_done) seg_done = 1'b0;
    else if (seg_valid) begin
      if (sg_cd == 0) sg_cd = 1 + int'($urandom % 4);
      else begin
        sg_cd--;
        if (sg_cd == 0) begin
          if (nseg < 8) begin got_a[nseg] = seg_addr; got_l[nseg] = seg_len; end
          nseg++;
          seg_done = 1'b1;
        end
      end
    end
  end

  always @(negedge clk) if (done) done_cnt++;

  task automatic load(input logic [31:0] base);
    for (int k = 0; k < 6; k++) begin
      mem[(base[9:2] + 8'(k * 4 + 0))] = ea[k][31:0];
      mem[(base[9:2] + 8'(k * 4 + 1))] = ea[k][63:32];
      mem[(base[9:2] + 8'(k * 4 + 2))] = ec[k];
      mem[(base[9:2] + 8'(k * 4 + 3))] = ef[k];
    end
  endtask

  // expected result from the requirements: outcome 0 = success, else code
  task automatic model(input logic [31:0] base, input logic [31:0] tot, input bit wr,
                       output int ns, output int outcome, output int visited);
    logic [31:0] rem, cl;
    rem = tot; ns = 0; outcome = 0; visited = 0;
    if (base[2:0] != 3'b000) begin outcome = 16; return; end
    if (tot == 0) return;
    for (int k = 0; k < 6; k++) begin
      visited = k + 1;
      cl = (ec[k] < rem) ? ec[k] : rem;
      if (cl != 0) begin xa[ns] = ea[k]; xl[ns] = cl; ns++; rem -= cl; end
      if (rem == 0) begin outcome = 0; break; end
      if (ef[k][31] || k == 5) begin outcome = wr ? 7 : 8; break; end
    end
  endtask

  task automatic run_walk(input logic [31:0] base, input logic [31:0] tot, input bit wr,
                          input bit inject, input string otag);
    int ns_e, out_e, vis_e, out_a, guard;
    model(base, tot, wr, ns_e, out_e, vis_e);
    nseg = 0; nreads = 0; rd_bad = 0; done_cnt = 0; cur_base = base;
    @(negedge clk);
    start = 1'b1; list_base = base; total_len = tot; dir_wr = wr;
    @(negedge clk);
    start = 1'b0;
    if (inject) begin
      repeat (3) @(negedge clk);
      start = 1'b1; list_base = base + 32'd3; total_len = 32'd1; dir_wr = ~wr;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (busy && guard < 20000) begin @(negedge clk); guard++; end
    @(negedge clk);
    chk(guard < 20000, otag, "walk finished", guard, 0);
    out_a = err ? int'(err_code) : ((done_cnt == 1) ? 0 : 99);
    chk(out_a == out_e, otag, "outcome code", out_a, out_e);
    chk(nseg == ns_e, "R3", "segment count", nseg, ns_e);
    for (int i = 0; i < ns_e && i < nseg && i < 8; i++) begin
      chk(got_a[i] == xa[i], "R3", "segment address", got_a[i], xa[i]);
      chk(got_l[i] == xl[i], "R3", "segment length", got_l[i], xl[i]);
    end
    chk(nreads == 4 * vis_e, "R2", "read count", nreads, 4 * vis_e);
    chk(rd_bad == 0, "R2", "read address order", rd_bad, 0);
  endtask

  task automatic set_ent(input int k, input logic [63:0] a, input logic [31:0] c, input bit last);
    ea[k] = a; ec[k] = c; ef[k] = last ? 32'h8000_0000 : 32'h0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !err && !seg_valid && !rd_req, "R1", "idle outputs",
        {busy, done, err, seg_valid, rd_req}, 0);
    chk(err_code == 0, "R1", "err_code", err_code, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4/R5: total exactly consumed at terminate entry
    set_ent(0, 64'h0000_0001_1000_0000, 32'd100, 0);
    set_ent(1, 64'h0000_0002_2000_0000, 32'd50, 0);
    set_ent(2, 64'hDEAD_0003_3000_0040, 32'd30, 1);
    set_ent(3, 64'h0, 32'd0, 0); set_ent(4, 64'h0, 32'd0, 0); set_ent(5, 64'h0, 32'd0, 0);
    load(32'h40);
    run_walk(32'h40, 32'd180, 1'b1, 1'b0, "R4");
    // R4: stops mid-list without terminate
    run_walk(32'h40, 32'd120, 1'b0, 1'b0, "R4");
    // R5: terminate reached early, write then read
    run_walk(32'h40, 32'd500, 1'b1, 1'b0, "R5");
    run_walk(32'h40, 32'd500, 1'b0, 1'b0, "R5");
    // R3: zero-count entry in middle
    set_ent(1, 64'h0000_0002_2000_0000, 32'd0, 0);
    load(32'h80);
    run_walk(32'h80, 32'd130, 1'b1, 1'b0, "R3");
    // R6: six entries, none terminated
    for (int k = 0; k < 6; k++) set_ent(k, {32'h0, 32'(k) * 32'h1000}, 32'd10, 0);
    load(32'h100);
    run_walk(32'h100, 32'd1000, 1'b1, 1'b0, "R6");
    run_walk(32'h100, 32'd1000, 1'b0, 1'b0, "R6");
    run_walk(32'h100, 32'd60, 1'b0, 1'b0, "R6");
    // R7 misaligned, then R9 sticky
    run_walk(32'h104, 32'd40, 1'b1, 1'b0, "R7");
    repeat (20) @(negedge clk);
    chk(err && err_code == 6'd16, "R9", "sticky error", {err, err_code}, {1'b1, 6'd16});
    chk(!seg_valid && !rd_req, "R9", "quiet while err", {seg_valid, rd_req}, 0);
    // R8 zero length; R9 cleared by accepted start
    run_walk(32'h100, 32'd0, 1'b1, 1'b0, "R8");
    chk(!err && err_code == 0, "R9", "error cleared", {err, err_code}, 0);
    // R10: start while busy ignored
    run_walk(32'h100, 32'd45, 1'b1, 1'b1, "R10");

    // random walks
    for (int t = 0; t < 40; t++) begin
      logic [31:0] b, tot;
      int lp;
      b = 32'(($urandom % 40) * 8);
      lp = int'($urandom % 8);
      for (int k = 0; k < 6; k++)
        set_ent(k, {$urandom, $urandom}, ($urandom % 4 == 0) ? 32'd0 : 32'($urandom % 200), k == lp);
      load(b);
      tot = 32'($urandom % 700);
      run_walk(b, tot, 1'($urandom % 2), 1'b0, "R4");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule